// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities (numbered 0 to 4) owns a shared register interface at any moment. Each locality sees its own register page, chosen by a 3-bit field in the bus address, and inside that page a single 8-bit access register through which software asks for the interface, gives it up, takes it by force, or acknowledges that it was taken. The block keeps one request flag, one seize flag and one seized-notification flag per locality. The active bit and the pending bit that software reads are computed from this state.

The rest of the chip sees the result as the number of the current owner, a flag that says no locality owns the interface, and a one-cycle pulse each time ownership lands on a new locality. When ownership must move while the command engine reports a command in flight, the block does not switch at once. It holds the chosen target, raises an abort request and moves ownership only when the abort-done acknowledge arrives. If no command is in flight, the handover happens in the cycle of the write.

Top module: `locarb_top`

## Requirements
- R1: After reset no locality is active (`none_active`=1, `active_loc`=0, no pulse, no abort request). The access register of every locality reads 0x80 with bit 0 equal to `est_flag`. Reads at any other offset, or of pages 5 to 7, return 0xFF.
- R2: `bus_addr[14:12]` selects the locality and `bus_addr[11:0]` the offset. The access register sits at offset 0x000. A write to any other offset changes no ownership state.
- R3: Writing bit 1 (request use) when no locality is active makes the writer the owner at the next clock edge, with `loc_changed` high for exactly one cycle. When another locality owns the interface, the write sets the writer's request flag, which reads back at bit 1. A request written by the current owner has no effect.
- R4: Bit 2 (pending) of a locality's access register reads as the OR of the request flags of all other localities.
- R5: When the owner writes 1 to bit 5 (active), ownership passes to the highest-numbered locality whose request flag is set. That locality's request flag is cleared. If no flag is set, no locality is active and no pulse is produced. If a write sets bit 5, its request bit is not acted on.
- R6: When a locality that is not the owner writes 1 to bit 5, only that locality's request flag is cleared.
- R7: A write of bit 3 (seize) is accepted only if no locality is active or the writer's number is above the owner's. It is ignored if the writer already has a seize outstanding or if a higher locality has one outstanding. A write with bit 3 set ignores its bits 5 and 1.
- R8: An accepted seize clears the seize flags of lower localities and hands ownership to the writer. The previous owner then reads bit 4 (been-seized) as 1 and bit 5 as 0. Bit 3 always reads 0.
- R9: Writing 1 to bit 4 clears the writer's been-seized flag.
- R10: Writes to locality 4 are ignored unless `bus_hw` is high during the write.
- R11: If a handover is due while `cmd_busy` is high, `abort_req` rises and the owner stays unchanged until a cycle with `abort_done` high. At that edge ownership moves to the held target, with a one-cycle `loc_changed` pulse, and `abort_req` falls. A later accepted handover replaces the held target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 15 | Locality in [14:12], register offset in [11:0] |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data for the access register |
| bus_hw | input | 1 | Hardware-access qualifier, needed for writes to locality 4 |
| est_flag | input | 1 | Value reported at bit 0 of every access register |
| cmd_busy | input | 1 | A command is executing; handovers must wait for an abort |
| abort_done | input | 1 | Acknowledge that the requested abort finished |
| rd_data | output | 8 | Combinational read data for the addressed register |
| active_loc | output | 3 | Current owner number (0 when none) |
| none_active | output | 1 | No locality owns the interface |
| loc_changed | output | 1 | One-cycle pulse when a new locality becomes owner |
| abort_req | output | 1 | Abort requested; held until abort_done |

## Verification
The bench first sweeps all eight pages and a non-access offset out of reset. It then takes every locality through request and release, including locality 4 with and without the hardware qualifier. A design that picks the lowest requester on release, or reports a pulse on release to no owner, shows the wrong owner or a stray `loc_changed`. Seizes from a lower locality, and from a lower one while a higher seize waits on an abort, must leave the outcome untouched; a design that retargets here would finish the abort on the wrong locality. The bench checks that the been-seized bit appears on the displaced owner only, and that ownership stays put across several busy cycles until the abort is acknowledged.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  localparam int ACC_W   = 8;
  localparam int B_VALID = 7;
  localparam int B_ACT   = 5;
  localparam int B_SEEN  = 4;
  localparam int B_SEIZE = 3;
  localparam int B_PEND  = 2;
  localparam int B_REQ   = 1;
  localparam int B_EST   = 0;
  localparam logic [ACC_W-1:0] NO_REG = 8'hFF;
endpackage

// File: rtl/locarb_decode.sv
module locarb_decode #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFF_W   = 12,
  parameter int ACC_OFF = 0,
  parameter int HW_LOC  = NUM_LOC - 1,
  localparam int ADDR_W = OFF_W + LOC_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              hw,
  output logic [LOC_W-1:0]  sel_loc,
  output logic              acc_hit,
  output logic              wr_ok
);
  logic off_match;
  logic loc_ok;
  logic hw_block;

  always_comb begin
    sel_loc   = addr[ADDR_W-1:OFF_W];
    off_match = (addr[OFF_W-1:0] == OFF_W'(ACC_OFF));
    loc_ok    = (int'(sel_loc) < NUM_LOC);
    acc_hit   = off_match && loc_ok;
    hw_block  = (int'(sel_loc) == HW_LOC) && !hw;
    wr_ok     = wr && acc_hit && !hw_block;
  end
endmodule

// File: rtl/locarb_pick.sv
module locarb_pick #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] req,
  output logic               found,
  output logic [LOC_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = LOC_W'(i);
      end
    end
  end
endmodule

// File: rtl/locarb_readmux.sv
module locarb_readmux
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [LOC_W-1:0]   sel_loc,
  input  logic               acc_hit,
  input  logic               owner_v,
  input  logic [LOC_W-1:0]   owner,
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seen,
  input  logic               est,
  output logic [ACC_W-1:0]   rd_data
);
  logic [NUM_LOC-1:0] others;
  logic [ACC_W-1:0]   word;

  always_comb begin
    for (int i = 0; i < NUM_LOC; i++) begin
      others[i] = req[i] && (LOC_W'(i) != sel_loc);
    end
    word          = '0;
    word[B_VALID] = 1'b1;
    word[B_ACT]   = owner_v && (owner == sel_loc);
    word[B_SEEN]  = seen[sel_loc];
    word[B_SEIZE] = 1'b0;
    word[B_PEND]  = |others;
    word[B_REQ]   = req[sel_loc];
    word[B_EST]   = est;
    rd_data       = acc_hit ? word : NO_REG;
  end
endmodule

// File: rtl/locarb_top.sv
module locarb_top
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFF_W   = 12,
  parameter int ACC_OFF = 0,
  localparam int ADDR_W = OFF_W + LOC_W,
  localparam int HW_LOC = NUM_LOC - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [ACC_W-1:0]  bus_wdata,
  input  logic              bus_hw,
  input  logic              est_flag,
  input  logic              cmd_busy,
  input  logic              abort_done,
  output logic [ACC_W-1:0]  rd_data,
  output logic [LOC_W-1:0]  active_loc,
  output logic              none_active,
  output logic              loc_changed,
  output logic              abort_req
);
  typedef struct packed {
    logic [LOC_W-1:0]   owner;
    logic               ov;
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] seize;
    logic [NUM_LOC-1:0] seen;
    logic               chg;
  } st_t;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // state
  logic [LOC_W-1:0]   owner_q;
  logic               ov_q;
  logic [NUM_LOC-1:0] req_q, seize_q, seen_q;
  logic               pend_q;
  logic [LOC_W-1:0]   next_q;
  logic               chg_q;

  // decode
  logic [LOC_W-1:0] sel_loc;
  logic             acc_hit, wr_ok;

  locarb_decode #(
    .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFF_W(OFF_W),
    .ACC_OFF(ACC_OFF), .HW_LOC(HW_LOC)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .hw(bus_hw),
    .sel_loc(sel_loc), .acc_hit(acc_hit), .wr_ok(wr_ok)
  );

  function automatic st_t hand_to(st_t s, logic [LOC_W-1:0] tgt);
    st_t r;
    r = s;
    if (s.ov && (s.owner != tgt)) begin
      if (s.seize[tgt]) r.seen[s.owner] = 1'b1;
      else              r.req[s.owner]  = 1'b0;
    end
    r.chg        = s.chg | !(s.ov && (s.owner == tgt));
    r.owner      = tgt;
    r.ov         = 1'b1;
    r.req[tgt]   = 1'b0;
    r.seize[tgt] = 1'b0;
    return r;
  endfunction

  // stage 1: finish an outstanding abort
  st_t mid_s;
  logic mid_pend;

  always_comb begin
    mid_s.owner = owner_q;
    mid_s.ov    = ov_q;
    mid_s.req   = req_q;
    mid_s.seize = seize_q;
    mid_s.seen  = seen_q;
    mid_s.chg   = 1'b0;
    mid_pend    = pend_q;
    if (pend_q && abort_done) begin
      mid_s    = hand_to(mid_s, next_q);
      mid_pend = 1'b0;
    end
  end

  logic             pick_found;
  logic [LOC_W-1:0] pick_idx;

  locarb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
    .req(mid_s.req), .found(pick_found), .idx(pick_idx)
  );

  // stage 2: apply a bus write to the access register
  st_t              nx_s;
  logic             nx_pend;
  logic [LOC_W-1:0] nx_next;
  logic [ACC_W-1:0] wv;
  logic             hand;
  logic [LOC_W-1:0] tgt;
  logic             higher_seize;
  logic             is_owner;

  always_comb begin
    nx_s         = mid_s;
    nx_pend      = mid_pend;
    nx_next      = next_q;
    wv           = bus_wdata;
    hand         = 1'b0;
    tgt          = '0;
    higher_seize = 1'b0;
    is_owner     = mid_s.ov && (mid_s.owner == sel_loc);
    for (int i = 0; i < NUM_LOC; i++) begin
      if (LOC_W'(i) > sel_loc && mid_s.seize[i]) higher_seize = 1'b1;
    end
    if (wr_ok) begin
      if (wv[B_SEIZE]) begin
        wv[B_REQ] = 1'b0;
        wv[B_ACT] = 1'b0;
      end
      if (wv[B_ACT]) begin
        if (is_owner) begin
          if (pick_found) begin
            hand = 1'b1;
            tgt  = pick_idx;
          end else begin
            nx_s.ov = 1'b0;
            nx_pend = 1'b0;
          end
        end else begin
          nx_s.req[sel_loc] = 1'b0;
        end
      end else if (wv[B_REQ] && !is_owner) begin
        if (mid_s.ov) begin
          nx_s.req[sel_loc] = 1'b1;
        end else begin
          hand = 1'b1;
          tgt  = sel_loc;
        end
      end
      if (wv[B_SEEN]) nx_s.seen[sel_loc] = 1'b0;
      if (wv[B_SEIZE] && (!mid_s.ov || sel_loc > mid_s.owner) &&
          !mid_s.seize[sel_loc] && !higher_seize) begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (LOC_W'(i) < sel_loc) nx_s.seize[i] = 1'b0;
        end
        nx_s.seize[sel_loc] = 1'b1;
        hand = 1'b1;
        tgt  = sel_loc;
      end
      if (hand) begin
        if (nx_s.ov && cmd_busy) begin
          nx_pend = 1'b1;
          nx_next = tgt;
        end else begin
          nx_s    = hand_to(nx_s, tgt);
          nx_pend = 1'b0;
        end
      end
    end
  end

  logic st_en;
  assign st_en = wr_ok || (pend_q && abort_done);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      ov_q    <= 1'b0;
      req_q   <= '0;
      seize_q <= '0;
      seen_q  <= '0;
      pend_q  <= 1'b0;
      next_q  <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= st_en && nx_s.chg;
      if (st_en) begin
        owner_q <= nx_s.owner;
        ov_q    <= nx_s.ov;
        req_q   <= nx_s.req;
        seize_q <= nx_s.seize;
        seen_q  <= nx_s.seen;
        pend_q  <= nx_pend;
        next_q  <= nx_next;
      end
    end
  end

  locarb_readmux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_readmux (
    .sel_loc(sel_loc), .acc_hit(acc_hit), .owner_v(ov_q), .owner(owner_q),
    .req(req_q), .seen(seen_q), .est(est_flag), .rd_data(rd_data)
  );

  assign active_loc  = ov_q ? owner_q : '0;
  assign none_active = !ov_q;
  assign loc_changed = chg_q;
  assign abort_req   = pend_q;

  // R3 / R5: the owner never holds its own request flag
  a_r3_owner_no_req: assert property (@(posedge clk) disable iff (!rst_ni)
    ov_q |-> !req_q[owner_q]);

  // R7: at most one seize outstanding at a time
  a_r7_one_seize: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(seize_q));

  // R3: a change pulse always names a valid, new owner
  a_r3_pulse_new_owner: assert property (@(posedge clk) disable iff (!rst_ni)
    st_en && nx_s.chg |=> ov_q && !($past(ov_q) && ($past(owner_q) == owner_q)));

  // R11: with an abort outstanding and no bus write, ownership holds
  a_r11_hold_owner: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_q && !abort_done && !bus_wr |=> (owner_q == $past(owner_q)) && ov_q && pend_q);

  // R10: a locality-4 write without the qualifier changes no flag of locality 4
  a_r10_hw_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_wr && (int'(sel_loc) == HW_LOC) && !bus_hw && !(pend_q && abort_done)
    |=> $stable(req_q) && $stable(seen_q) && $stable(ov_q));

  // R5: release to nobody gives no pulse
  a_r5_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    chg_q |-> ov_q);
endmodule

// File: tb/locarb_top_tb.sv
module locarb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] bus_addr;
  logic        bus_wr, bus_hw, est_flag, cmd_busy, abort_done;
  logic [7:0]  bus_wdata, rd_data;
  logic [2:0]  active_loc;
  logic        none_active, loc_changed, abort_req;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  locarb_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_hw(bus_hw), .est_flag(est_flag),
    .cmd_busy(cmd_busy), .abort_done(abort_done), .rd_data(rd_data),
    .active_loc(active_loc), .none_active(none_active),
    .loc_changed(loc_changed), .abort_req(abort_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int loc, logic [7:0] v, logic hw = 1'b0, int off = 0);
    @(negedge clk);
    bus_addr  = {3'(loc), 12'(off)};
    bus_wdata = v;
    bus_wr    = 1'b1;
    bus_hw    = hw;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_hw    = 1'b0;
  endtask

  task automatic rd(int loc, int off, output logic [7:0] d);
    bus_addr = {3'(loc), 12'(off)};
    #1;
    d = rd_data;
  endtask

  task automatic chk_rd(string tag, int loc, int exp);
    logic [7:0] d;
    rd(loc, 0, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_own(string tag, int loc, int pulse);
    chk({tag, " owner"}, active_loc, loc);
    chk({tag, " none"}, none_active, 0);
    chk({tag, " pulse"}, loc_changed, pulse);
  endtask

  // access word: valid | act<<5 | seen<<4 | pend<<2 | req<<1 | est
  function automatic int acc(int act, int seen, int pend, int req, int est);
    return 8'h80 | (act << 5) | (seen << 4) | (pend << 2) | (req << 1) | est;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_hw = 0; bus_wdata = '0;
    est_flag = 0; cmd_busy = 0; abort_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2: reset sweep of all pages and a non-access offset
    chk("R1 none_active", none_active, 1);
    chk("R1 active_loc", active_loc, 0);
    chk("R1 loc_changed", loc_changed, 0);
    chk("R1 abort_req", abort_req, 0);
    for (int p = 0; p < 8; p++) begin
      rd(p, 0, d);
      chk($sformatf("R1 page %0d", p), d, (p < 5) ? 8'h80 : 8'hFF);
    end
    rd(0, 4, d);
    chk("R2 other offset", d, 8'hFF);

    // R3 / R5 / R10: each locality requests from idle then releases
    for (int l = 0; l < 5; l++) begin
      wr(l, 8'h02, l == 4);
      chk_own($sformatf("R3 take %0d", l), l, 1);
      chk_rd($sformatf("R3 read %0d", l), l, acc(1, 0, 0, 0, 0));
      wr(l, 8'h20, l == 4);
      chk($sformatf("R5 release %0d none", l), none_active, 1);
      chk($sformatf("R5 release %0d pulse", l), loc_changed, 0);
    end

    // R10: locality 4 without qualifier
    wr(4, 8'h02, 1'b0);
    chk("R10 no hw none_active", none_active, 1);
    chk_rd("R10 no hw read", 4, acc(0, 0, 0, 0, 0));

    // R3 / R4: queued requests and pending bits
    wr(2, 8'h02);
    chk_own("R3 owner 2", 2, 1);
    wr(1, 8'h02);
    chk_rd("R3 req flag 1", 1, acc(0, 0, 0, 1, 0));
    chk_rd("R4 pend on 2", 2, acc(1, 0, 1, 0, 0));
    chk_rd("R4 pend on 0", 0, acc(0, 0, 1, 0, 0));
    wr(2, 8'h02);
    chk_own("R3 owner request no effect", 2, 0);
    chk_rd("R3 owner read", 2, acc(1, 0, 1, 0, 0));
    wr(3, 8'h02);
    chk_rd("R4 pend on 1 from 3", 1, acc(0, 0, 1, 1, 0));

    // R5: release goes to highest requester
    wr(2, 8'h20);
    chk_own("R5 release to 3", 3, 1);
    chk_rd("R5 new owner 3", 3, acc(1, 0, 1, 0, 0));
    chk_rd("R5 old owner 2", 2, acc(0, 0, 1, 0, 0));

    // R6: non-owner clears only its request
    wr(1, 8'h20);
    chk_rd("R6 req1 cleared", 1, acc(0, 0, 0, 0, 0));
    chk_own("R6 owner unchanged", 3, 0);
    chk_rd("R6 owner read", 3, acc(1, 0, 0, 0, 0));

    // R7: lower seize ignored, unqualified locality 4 ignored
    wr(1, 8'h08);
    chk_own("R7 lower seize ignored", 3, 0);
    wr(4, 8'h08, 1'b0);
    chk_own("R10 seize w/o hw ignored", 3, 0);

    // R8: accepted seize by 4
    wr(4, 8'h08, 1'b1);
    chk_own("R8 seize by 4", 4, 1);
    chk_rd("R8 old owner seized", 3, acc(0, 1, 0, 0, 0));
    chk_rd("R8 new owner", 4, acc(1, 0, 0, 0, 0));

    // R9: clear been-seized
    wr(3, 8'h10);
    chk_rd("R9 seen cleared", 3, acc(0, 0, 0, 0, 0));

    // R11: release while busy waits for abort
    wr(0, 8'h02);
    cmd_busy = 1'b1;
    wr(4, 8'h20, 1'b1);
    chk("R11 abort_req up", abort_req, 1);
    chk_own("R11 owner held", 4, 0);
    repeat (3) @(negedge clk);
    chk_own("R11 owner still held", 4, 0);
    chk("R11 abort_req held", abort_req, 1);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
    chk_own("R11 handover on done", 0, 1);
    chk("R11 abort_req down", abort_req, 0);
    chk_rd("R11 old owner", 4, acc(0, 0, 0, 0, 0));
    chk_rd("R11 new owner", 0, acc(1, 0, 0, 0, 0));

    // R7 / R8 / R11: seize during abort; lower seize must not retarget
    wr(3, 8'h08);
    chk("R11 seize abort_req", abort_req, 1);
    chk_own("R11 seize owner held", 0, 0);
    chk_rd("R8 seize bit hidden", 3, acc(0, 0, 0, 0, 0));
    wr(2, 8'h08);
    chk("R7 abort still up", abort_req, 1);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
    chk_own("R7 higher seize wins", 3, 1);
    chk_rd("R8 seized after abort", 0, acc(0, 1, 0, 0, 0));
    chk_rd("R7 loc2 untouched", 2, acc(0, 0, 0, 0, 0));
    cmd_busy = 1'b0;

    // R7: seize when nobody active takes ownership at once
    wr(3, 8'h20);
    chk("R5 release none", none_active, 1);
    wr(1, 8'h08);
    chk_own("R7 seize from idle", 1, 1);

    // R2: write at another offset changes nothing
    wr(2, 8'h02, 1'b0, 8);
    chk_own("R2 off-page write", 1, 0);
    chk_rd("R2 off-page read", 2, acc(0, 0, 0, 0, 0));

    // R1: establishment flag passes to bit 0
    est_flag = 1'b1;
    chk_rd("R1 est bit", 1, acc(1, 0, 0, 0, 1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule